// File: doc/BRIEF.md
# Two-Road Intersection Signal Controller with Emergency Preemption

This block sequences the lamps of a crossing where two roads, A and B, share the right-of-way. In normal service it steps through four phases in a fixed ring: A go, A warn, B go, B warn. An internal phase timer and a vehicle sensor on each road decide when a green ends. A green runs for at least a minimum time and ends early only when the crossing road's sensor reports waiting traffic. It never runs past a maximum time. Each warn (yellow) phase has a fixed length.

Two emergency request inputs preempt the ring. A request on road A moves the controller into a dedicated A-priority state, with A green and B red. A request on road B does the same for road B. Either move happens as soon as the synchronised request reaches the next-state logic, with no yellow in between. When a request clears, the controller leaves the priority state through the yellow phase of the road that held green, and only then gives green to the other road.

All sensor and emergency inputs pass through a two-flop synchroniser. The lamp outputs are decoded from the state register alone, so they form a Moore machine.

States (3-bit code): A go `000`, A warn `001`, B go `010`, B warn `011`, A priority `100`, B priority `101`. The codes `110` and `111` are unused.

Transitions:
- A go → A warn: maximum green reached, or minimum green reached while the B sensor is set.
- A warn → B go: after the yellow time.
- B go → B warn: maximum green reached, or minimum green reached while the A sensor is set.
- B warn → A go: after the yellow time.
- Any state → A priority: while the A request is set.
- Any state → B priority: while the B request is set and the A request is clear.
- A priority → A warn: when the requests clear.
- B priority → B warn: when the requests clear.
- Unused code → A go.

Top module: `intersection_ctrl`

## Requirements
- R1: An active-low asynchronous reset places the state in A go, which drives lamp_a = 001 and lamp_b = 100. The state register holds only the codes 000 to 101, and an unused code 110 or 111 is followed by A go at the next edge.
- R2: Each lamp vector is one-hot with bit 2 = red, bit 1 = yellow and bit 0 = green. The lamps depend only on the state. A go and A priority drive A green with B red. B go and B priority drive B green with A red. A warn drives A yellow with B red. B warn drives B yellow with A red. At least one road is always red.
- R3: A request set at the inputs enters its priority state on the third rising edge after it is applied (two synchroniser flops, then the state register), from any state and without a yellow phase. The priority state holds while the request stays set.
- R4: When both requests are set, A priority wins and holds while emerg_a stays set. Once emerg_a clears while emerg_b is still set, B priority follows.
- R5: When the requests clear, A priority moves to A warn and then to B go. B priority moves to B warn and then to A go.
- R6: Without emergency requests the state follows the ring A go → A warn → B go → B warn → A go, and never moves straight from one road's green to the other road's green.
- R7: A green lasts at least MIN_GREEN cycles (default 16). When the crossing road's synchronised sensor is already set, the green lasts exactly MIN_GREEN cycles.
- R8: With the crossing road's sensor clear, a green lasts exactly MAX_GREEN cycles (default 64). No green ever exceeds MAX_GREEN cycles.
- R9: Every yellow phase lasts exactly YELLOW_LEN cycles (default 4).
- R10: The phase timer restarts from zero on every state change, including entry to and exit from a priority state. A yellow that follows a priority state therefore also lasts exactly YELLOW_LEN cycles.
- R11: A sensor change reaches the next-state logic through two synchroniser flops. A sensor raised while a green is past its minimum time ends that green on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sensor_a | input | 1 | Vehicle waiting on road A (asynchronous) |
| sensor_b | input | 1 | Vehicle waiting on road B (asynchronous) |
| emerg_a | input | 1 | Emergency request for road A (asynchronous) |
| emerg_b | input | 1 | Emergency request for road B (asynchronous) |
| lamp_a | output | 3 | Road A lamps: bit 2 red, bit 1 yellow, bit 0 green |
| lamp_b | output | 3 | Road B lamps: bit 2 red, bit 1 yellow, bit 0 green |

## Verification
The lamps are decoded directly from the state register, so a corrupted state shows at the ports in the same cycle. It appears either as an illegal lamp pair or as a phase out of its ring order. A timer fault shows up as a green or yellow that is one or more cycles too long or too short. The bench measures these durations edge by edge. A fault in the synchroniser or the priority logic shifts the three-edge response to a request. It may also leave the wrong road green when both requests are present. A cycle-accurate reference model compares both lamp vectors on every clock for the whole run, so any divergence is reported within one cycle of its appearance.

// File: rtl/intersection_pkg.sv
package intersection_pkg;

    // State codes; the values are fixed by the lamp and recovery behaviour
    typedef enum logic [2:0] {
        ST_A_GO   = 3'b000,
        ST_A_WARN = 3'b001,
        ST_B_GO   = 3'b010,
        ST_B_WARN = 3'b011,
        ST_A_PRIO = 3'b100,
        ST_B_PRIO = 3'b101
    } light_state_e;

    // Lamp vectors: bit 2 red, bit 1 yellow, bit 0 green
    localparam logic [2:0] LAMP_RED   = 3'b100;
    localparam logic [2:0] LAMP_AMBER = 3'b010;
    localparam logic [2:0] LAMP_GREEN = 3'b001;

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int LIMIT = 64,
    parameter int TW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [TW-1:0] count
);

    localparam logic [TW-1:0] TOP = TW'(LIMIT - 1);

    // Counts cycles spent in the current state, saturating at LIMIT-1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
    import intersection_pkg::*;
(
    input  light_state_e state,
    output logic [2:0]   lamp_a,
    output logic [2:0]   lamp_b
);

    always_comb begin
        unique case (state)
            ST_A_GO, ST_A_PRIO: begin
                lamp_a = LAMP_GREEN;
                lamp_b = LAMP_RED;
            end
            ST_A_WARN: begin
                lamp_a = LAMP_AMBER;
                lamp_b = LAMP_RED;
            end
            ST_B_GO, ST_B_PRIO: begin
                lamp_a = LAMP_RED;
                lamp_b = LAMP_GREEN;
            end
            ST_B_WARN: begin
                lamp_a = LAMP_RED;
                lamp_b = LAMP_AMBER;
            end
            default: begin
                lamp_a = LAMP_RED;
                lamp_b = LAMP_RED;
            end
        endcase
    end

endmodule

// File: rtl/intersection_ctrl.sv
module intersection_ctrl
    import intersection_pkg::*;
#(
    parameter int MIN_GREEN   = 16,
    parameter int MAX_GREEN   = 64,
    parameter int YELLOW_LEN  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sensor_a,
    input  logic       sensor_b,
    input  logic       emerg_a,
    input  logic       emerg_b,
    output logic [2:0] lamp_a,
    output logic [2:0] lamp_b
);

    localparam int TW = $clog2(MAX_GREEN + 1);
    localparam logic [TW-1:0] MIN_LAST   = TW'(MIN_GREEN - 1);
    localparam logic [TW-1:0] MAX_LAST   = TW'(MAX_GREEN - 1);
    localparam logic [TW-1:0] AMBER_LAST = TW'(YELLOW_LEN - 1);

    logic [3:0]   raw_in;
    logic [3:0]   syn_in;
    logic         sns_a_s, sns_b_s, emg_a_s, emg_b_s;
    logic [TW-1:0] tmr;
    logic         restart;
    light_state_e state_q, state_d;
    logic         a_green_done, b_green_done, amber_done;

    assign raw_in = {emerg_b, emerg_a, sensor_b, sensor_a};

    sync_bank #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {emg_b_s, emg_a_s, sns_b_s, sns_a_s} = syn_in;

    phase_timer #(
        .LIMIT (MAX_GREEN),
        .TW    (TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (tmr)
    );

    assign a_green_done = (tmr == MAX_LAST) || ((tmr >= MIN_LAST) && sns_b_s);
    assign b_green_done = (tmr == MAX_LAST) || ((tmr >= MIN_LAST) && sns_a_s);
    assign amber_done   = (tmr == AMBER_LAST);

    // Next-state logic: emergencies first (A over B), then the normal ring
    always_comb begin
        state_d = state_q;
        if (emg_a_s) begin
            state_d = ST_A_PRIO;
        end else if (emg_b_s) begin
            state_d = ST_B_PRIO;
        end else begin
            unique case (state_q)
                ST_A_GO:   if (a_green_done) state_d = ST_A_WARN;
                ST_A_WARN: if (amber_done)   state_d = ST_B_GO;
                ST_B_GO:   if (b_green_done) state_d = ST_B_WARN;
                ST_B_WARN: if (amber_done)   state_d = ST_A_GO;
                ST_A_PRIO: state_d = ST_A_WARN;
                ST_B_PRIO: state_d = ST_B_WARN;
                default:   state_d = ST_A_GO;
            endcase
        end
    end

    assign restart = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_A_GO;
        end else begin
            state_q <= state_d;
        end
    end

    lamp_decode u_lamps (
        .state  (state_q),
        .lamp_a (lamp_a),
        .lamp_b (lamp_b)
    );

endmodule

// File: rtl/intersection_ctrl_chk.sv
module intersection_ctrl_chk
    import intersection_pkg::*;
#(
    parameter int MAX_GREEN   = 64,
    parameter int YELLOW_LEN  = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         emerg_a,
    input logic         emerg_b,
    input light_state_e state_q,
    input logic [2:0]   lamp_a,
    input logic [2:0]   lamp_b
);

    localparam int RW = $clog2(MAX_GREEN + 2) + 1;

    logic [SYNC_STAGES-1:0] pa, pb;
    light_state_e           last_q;
    logic [RW-1:0]          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa     <= '0;
            pb     <= '0;
            last_q <= ST_A_GO;
            run    <= '0;
        end else begin
            pa     <= {pa[SYNC_STAGES-2:0], emerg_a};
            pb     <= {pb[SYNC_STAGES-2:0], emerg_b};
            last_q <= state_q;
            if (state_q != last_q || run == '0) run <= RW'(1);
            else if (run != '1)                 run <= run + 1'b1;
        end
    end

    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_A_GO, ST_A_WARN, ST_B_GO, ST_B_WARN, ST_A_PRIO, ST_B_PRIO});

    // R2
    lamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lamp_a) && $onehot(lamp_b));

    // R2
    one_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_a[2] || lamp_b[2]);

    // R3
    prio_a_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pa[SYNC_STAGES-1] |=> state_q == ST_A_PRIO);

    // R4
    prio_b_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb[SYNC_STAGES-1] && !pa[SYNC_STAGES-1]) |=> state_q == ST_B_PRIO);

    // R5
    prio_a_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_A_PRIO |=> state_q inside {ST_A_PRIO, ST_A_WARN, ST_B_PRIO});

    // R5
    prio_b_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_B_PRIO |=> state_q inside {ST_B_PRIO, ST_B_WARN, ST_A_PRIO});

    // R6
    a_go_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_A_GO |=> state_q inside {ST_A_GO, ST_A_WARN, ST_A_PRIO, ST_B_PRIO});

    // R6
    b_go_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_B_GO |=> state_q inside {ST_B_GO, ST_B_WARN, ST_A_PRIO, ST_B_PRIO});

    // R8
    green_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q inside {ST_A_GO, ST_B_GO}) |-> run <= RW'(MAX_GREEN));

    // R9
    amber_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q inside {ST_A_WARN, ST_B_WARN}) |-> run <= RW'(YELLOW_LEN));

endmodule

bind intersection_ctrl intersection_ctrl_chk #(
    .MAX_GREEN   (MAX_GREEN),
    .YELLOW_LEN  (YELLOW_LEN),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .emerg_a (emerg_a),
    .emerg_b (emerg_b),
    .state_q (state_q),
    .lamp_a  (lamp_a),
    .lamp_b  (lamp_b)
);

// File: tb/intersection_ctrl_tb.sv
`timescale 1ns/1ps
module intersection_ctrl_tb;

    localparam int MIN_G = 16;
    localparam int MAX_G = 64;
    localparam int YEL   = 4;
    localparam logic [2:0] RED = 3'b100;
    localparam logic [2:0] AMB = 3'b010;
    localparam logic [2:0] GRN = 3'b001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sensor_a = 1'b0, sensor_b = 1'b0, emerg_a = 1'b0, emerg_b = 1'b0;
    logic [2:0] lamp_a, lamp_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    intersection_ctrl #(
        .MIN_GREEN   (MIN_G),
        .MAX_GREEN   (MAX_G),
        .YELLOW_LEN  (YEL),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sensor_a (sensor_a),
        .sensor_b (sensor_b),
        .emerg_a  (emerg_a),
        .emerg_b  (emerg_b),
        .lamp_a   (lamp_a),
        .lamp_b   (lamp_b)
    );

    // Reference model, states 0..5 as in the requirements
    int m_st, m_t;
    logic [3:0] m_s1, m_s2;

    function automatic int ref_next(int s, int t, logic [3:0] syn);
        logic sa, sb, ea, eb;
        {eb, ea, sb, sa} = syn;
        if (ea) return 4;
        if (eb) return 5;
        case (s)
            0: return (t == MAX_G-1 || (t >= MIN_G-1 && sb)) ? 1 : 0;
            1: return (t == YEL-1) ? 2 : 1;
            2: return (t == MAX_G-1 || (t >= MIN_G-1 && sa)) ? 3 : 2;
            3: return (t == YEL-1) ? 0 : 3;
            4: return 1;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [5:0] ref_lamps(int s);
        case (s)
            0, 4: return {GRN, RED};
            1:    return {AMB, RED};
            2, 5: return {RED, GRN};
            3:    return {RED, AMB};
            default: return {RED, RED};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_t <= 0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            int ns;
            ns = ref_next(m_st, m_t, m_s2);
            m_t  <= (ns != m_st) ? 0 : ((m_t < MAX_G-1) ? m_t + 1 : m_t);
            m_st <= ns;
            m_s1 <= {emerg_b, emerg_a, sensor_b, sensor_a};
            m_s2 <= m_s1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle lamp comparison against the model (R2, R6)
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            logic [5:0] e;
            e = ref_lamps(m_st);
            check({lamp_a, lamp_b} == e, "R2 R6 lamp pair", {lamp_a, lamp_b}, e);
        end
    end

    task automatic dur_a(input logic [2:0] v, output int n);
        n = 0;
        while (lamp_a == v) begin n++; @(negedge clk); end
    endtask
    task automatic dur_b(input logic [2:0] v, output int n);
        n = 0;
        while (lamp_b == v) begin n++; @(negedge clk); end
    endtask
    task automatic until_a(input logic [2:0] v, output int n);
        n = 0;
        while (lamp_a != v) begin @(negedge clk); n++; end
    endtask
    task automatic until_b(input logic [2:0] v, output int n);
        n = 0;
        while (lamp_b != v) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'h1badf00d));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(lamp_a == GRN && lamp_b == RED, "R1 reset lamps", {lamp_a, lamp_b}, {GRN, RED});
        rst_n = 1'b1;
        cmp_en = 1;

        // R8: sensors low, B green runs to the maximum
        until_b(GRN, n);
        dur_b(GRN, n);
        check(n == MAX_G, "R8 max green length", n, MAX_G);
        dur_b(AMB, n);
        check(n == YEL, "R9 yellow length", n, YEL);

        // R11: sensor past minimum ends A green on the third edge
        check(lamp_a == GRN, "R6 ring B warn to A go", lamp_a, GRN);
        repeat (20) @(negedge clk);
        sensor_b = 1'b1;
        until_a(AMB, n);
        check(n == 3, "R11 sensor latency", n, 3);

        // R7: crossing sensor already set -> exactly the minimum
        sensor_a = 1'b1;
        until_b(GRN, n);
        dur_b(GRN, n);
        check(n == MIN_G, "R7 min green B", n, MIN_G);
        dur_b(AMB, n);
        dur_a(GRN, n);
        check(n == MIN_G, "R7 min green A", n, MIN_G);
        sensor_a = 1'b0;
        sensor_b = 1'b0;

        // R3: emergency B from A green, no yellow
        until_b(GRN, n);
        until_a(GRN, n);
        repeat (5) @(negedge clk);
        emerg_b = 1'b1;
        until_b(GRN, n);
        check(n == 3 && lamp_a == RED, "R3 emergency entry latency", n, 3);
        repeat (10) @(negedge clk);
        check(lamp_b == GRN && lamp_a == RED, "R3 emergency hold", {lamp_a, lamp_b}, {RED, GRN});
        emerg_b = 1'b0;
        until_b(AMB, n);
        check(n == 3, "R5 exit via own yellow", n, 3);
        dur_b(AMB, n);
        check(n == YEL, "R10 yellow after emergency", n, YEL);
        check(lamp_a == GRN, "R5 other road green after yellow", lamp_a, GRN);

        // R4: both requests from B green
        until_b(GRN, n);
        repeat (3) @(negedge clk);
        emerg_a = 1'b1;
        emerg_b = 1'b1;
        until_a(GRN, n);
        check(n == 3 && lamp_b == RED, "R4 A wins tie", n, 3);
        repeat (10) @(negedge clk);
        check(lamp_a == GRN && lamp_b == RED, "R4 A holds with both", {lamp_a, lamp_b}, {GRN, RED});
        emerg_a = 1'b0;
        until_b(GRN, n);
        check(n == 3, "R4 B follows when A clears", n, 3);
        emerg_b = 1'b0;
        until_b(AMB, n);
        dur_b(AMB, n);
        check(n == YEL, "R10 yellow after B priority", n, YEL);

        // Random traffic with occasional emergencies
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if ($urandom_range(0, 19) == 0) sensor_a = ~sensor_a;
            if ($urandom_range(0, 19) == 0) sensor_b = ~sensor_b;
            if (emerg_a || emerg_b) begin
                if ($urandom_range(0, 15) == 0) begin emerg_a = 1'b0; emerg_b = 1'b0; end
            end else if ($urandom_range(0, 299) == 0) begin
                int k;
                k = $urandom_range(0, 2);
                emerg_a = (k != 1);
                emerg_b = (k != 0);
            end
        end
        emerg_a = 1'b0;
        emerg_b = 1'b0;
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule